// File: doc/BRIEF.md
# Dual Descriptor Ring Pointer Manager

This block tracks where a network controller stands in two circular lists of buffer descriptors kept in host memory: one list for outgoing frames and one for incoming frames. Each list starts at its own base address and holds its own number of entries. Every descriptor takes 8 bytes and describes exactly one buffer. A frame that spans several buffers uses consecutive descriptors. The block presents the byte address of the current descriptor of each list. It steps a list forward when its consumer reports that an entry is finished, and goes back to entry 0 after the last entry.

A control state machine has four states: `ST_IDLE` (after reset, no configuration yet), `ST_RUN` (pointers may advance), `ST_SUSP` (frozen, positions kept) and `ST_ERR` (an illegal configuration was loaded). The transitions are:
- `init_i` goes from any state to `ST_RUN`, or to `ST_ERR` when the presented configuration is illegal.
- `suspend_i` goes from `ST_RUN` to `ST_SUSP`.
- `resume_i` goes from `ST_SUSP` back to `ST_RUN`.
- `restart_i` goes from `ST_RUN` or `ST_SUSP` to `ST_RUN` and sends both pointers back to their bases.
- `ST_ERR` and `ST_IDLE` leave only on `init_i`.

The descriptor fetch, the ownership checks and the buffer transfers belong to other blocks.

Top module: `desc_ring_ptr_mgr`

## Requirements
- R1: `init_i` captures both bases and both lengths from the inputs and sets both indices to 0. From the next cycle on, each address output equals its captured base, and the error flag is low when the configuration is legal.
- R2: Each address output equals its captured base plus 8 times its current index, modulo 2^32.
- R3: The transmit and receive pointers are independent. An advance strobe moves only its own ring, by one entry, one cycle after the strobe. Strobes on both rings in the same cycle move both rings.
- R4: An advance at index length−1 returns that ring to index 0. A length of 128 is legal and wraps after entry 127.
- R5: If either captured base has a nonzero value in bits [2:0], `cfg_err_o` is 1 from the cycle after `init_i`.
- R6: If either captured length is 0 or greater than 128, `cfg_err_o` is 1 from the cycle after `init_i`.
- R7: While `cfg_err_o` is 1, advance strobes, `restart_i`, `suspend_i` and `resume_i` leave both addresses and the flag unchanged. Only an `init_i` with a legal configuration clears the flag.
- R8: In `ST_RUN` or `ST_SUSP`, `restart_i` puts both addresses back to their bases one cycle later, keeps the captured configuration, and leaves the block in `ST_RUN`.
- R9: `suspend_i` in `ST_RUN` enters `ST_SUSP`. In `ST_SUSP`, advance strobes are ignored. `resume_i` returns to `ST_RUN` with both pointers at the entries they held when suspend began.
- R10: Priority in one cycle is `init_i` over `restart_i` over `suspend_i`/`resume_i`. An advance in the same cycle as `init_i` or `restart_i` is dropped. An advance in the same cycle as `suspend_i` in `ST_RUN` is taken.
- R11: After reset, both addresses and `cfg_err_o` are 0, and advance strobes before the first `init_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Capture configuration and zero both indices |
| restart_i | input | 1 | Return both pointers to their bases |
| suspend_i | input | 1 | Freeze both pointers |
| resume_i | input | 1 | Leave the frozen state, keeping positions |
| tx_base_i | input | 32 | Transmit ring base byte address |
| tx_len_i | input | 8 | Transmit ring entry count |
| rx_base_i | input | 32 | Receive ring base byte address |
| rx_len_i | input | 8 | Receive ring entry count |
| tx_adv_i | input | 1 | Transmit entry consumed |
| rx_adv_i | input | 1 | Receive entry consumed |
| tx_desc_addr_o | output | 32 | Current transmit descriptor address |
| rx_desc_addr_o | output | 32 | Current receive descriptor address |
| cfg_err_o | output | 1 | Illegal configuration captured |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples its control input. This covers a new address after an advance, restart or init, the error flag after init, and the frozen state after suspend. The address outputs follow the index registers through adders only, with no further register. The bench therefore changes inputs just after a falling edge and reads the outputs at the next falling edge, which lies after the one rising edge that must have applied the change. Expected addresses come from a per-ring count of accepted advances, computed as base + 8 × (count mod length).

// File: rtl/drp_pkg.sv
package drp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2,
        ST_ERR  = 2'd3
    } mgr_state_e;
endpackage

// File: rtl/drp_cfg_check.sv
module drp_cfg_check #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 8,
    parameter int MAX_ENTRIES = 128,
    parameter int ALIGN_BITS  = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              bad_o
);
    logic misaligned;
    logic len_bad;

    always_comb begin
        misaligned = |base_i[ALIGN_BITS-1:0];
        len_bad    = (len_i == '0) || (len_i > LEN_W'(MAX_ENTRIES));
        bad_o      = misaligned || len_bad;
    end
endmodule

// File: rtl/drp_ring_index.sv
module drp_ring_index #(
    parameter int IDX_W = 7,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [IDX_W-1:0] idx_o
);
    logic             at_last;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        at_last  = ((LEN_W'(idx_o) + LEN_W'(1)) == len_i);
        idx_next = idx_o;
        if (clear_i)
            idx_next = '0;
        else if (adv_i)
            idx_next = at_last ? '0 : idx_o + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_o <= '0;
        else
            idx_o <= idx_next;
    end

    // R4: an advance at the last entry comes back to entry 0
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i && at_last) |=> (idx_o == '0));

    // R4: a nonzero length keeps the index inside the ring
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i != '0) |-> (LEN_W'(idx_o) < len_i));
endmodule

// File: rtl/drp_ctrl_fsm.sv
module drp_ctrl_fsm
    import drp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_i,
    input  logic       cfg_bad_i,
    input  logic       restart_i,
    input  logic       suspend_i,
    input  logic       resume_i,
    output mgr_state_e state_o,
    output logic       load_o,
    output logic       clear_o,
    output logic       adv_en_o,
    output logic       err_o
);
    mgr_state_e state_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_o <= ST_IDLE;
        else
            state_o <= state_next;
    end

    always_comb begin
        state_next = state_o;
        if (init_i) begin
            state_next = cfg_bad_i ? ST_ERR : ST_RUN;
        end else begin
            unique case (state_o)
                ST_IDLE: state_next = ST_IDLE;
                ST_RUN: begin
                    if (restart_i)      state_next = ST_RUN;
                    else if (suspend_i) state_next = ST_SUSP;
                end
                ST_SUSP: begin
                    if (restart_i || resume_i) state_next = ST_RUN;
                end
                ST_ERR:  state_next = ST_ERR;
                default: state_next = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o   = init_i;
        clear_o  = init_i;
        adv_en_o = 1'b0;
        err_o    = 1'b0;
        unique case (state_o)
            ST_IDLE: ;
            ST_RUN: begin
                clear_o  = init_i || restart_i;
                adv_en_o = !init_i && !restart_i;
            end
            ST_SUSP: clear_o = init_i || restart_i;
            ST_ERR:  err_o   = 1'b1;
            default: ;
        endcase
    end

    // R10: an index is never cleared and advanced in the same cycle
    p_adv_excl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_en_o && clear_o));

    // R9: a suspended manager leaves only through init, restart or resume
    p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SUSP && !init_i && !restart_i && !resume_i) |=> (state_o == ST_SUSP));
endmodule

// File: rtl/desc_ring_ptr_mgr.sv
module desc_ring_ptr_mgr
    import drp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MAX_ENTRIES = 128,
    parameter int DESC_BYTES  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            init_i,
    input  logic                            restart_i,
    input  logic                            suspend_i,
    input  logic                            resume_i,
    input  logic [ADDR_W-1:0]               tx_base_i,
    input  logic [$clog2(MAX_ENTRIES+1)-1:0] tx_len_i,
    input  logic [ADDR_W-1:0]               rx_base_i,
    input  logic [$clog2(MAX_ENTRIES+1)-1:0] rx_len_i,
    input  logic                            tx_adv_i,
    input  logic                            rx_adv_i,
    output logic [ADDR_W-1:0]               tx_desc_addr_o,
    output logic [ADDR_W-1:0]               rx_desc_addr_o,
    output logic                            cfg_err_o
);
    localparam int LEN_W      = $clog2(MAX_ENTRIES + 1);
    localparam int IDX_W      = $clog2(MAX_ENTRIES);
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int NUM_RINGS  = 2;

    logic [NUM_RINGS-1:0][ADDR_W-1:0] base_in;
    logic [NUM_RINGS-1:0][LEN_W-1:0]  len_in;
    logic [NUM_RINGS-1:0]             adv_in;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] base_q;
    logic [NUM_RINGS-1:0][LEN_W-1:0]  len_q;
    logic [NUM_RINGS-1:0][IDX_W-1:0]  idx;
    logic [NUM_RINGS-1:0][ADDR_W-1:0] addr;
    logic [NUM_RINGS-1:0]             ring_bad;

    mgr_state_e state;
    logic       load;
    logic       clear;
    logic       adv_en;
    logic       cfg_bad;

    assign base_in[0] = tx_base_i;
    assign base_in[1] = rx_base_i;
    assign len_in[0]  = tx_len_i;
    assign len_in[1]  = rx_len_i;
    assign adv_in[0]  = tx_adv_i;
    assign adv_in[1]  = rx_adv_i;
    assign cfg_bad    = |ring_bad;

    drp_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .cfg_bad_i (cfg_bad),
        .restart_i (restart_i),
        .suspend_i (suspend_i),
        .resume_i  (resume_i),
        .state_o   (state),
        .load_o    (load),
        .clear_o   (clear),
        .adv_en_o  (adv_en),
        .err_o     (cfg_err_o)
    );

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        drp_cfg_check #(
            .ADDR_W      (ADDR_W),
            .LEN_W       (LEN_W),
            .MAX_ENTRIES (MAX_ENTRIES),
            .ALIGN_BITS  (DESC_SHIFT)
        ) u_chk (
            .base_i (base_in[r]),
            .len_i  (len_in[r]),
            .bad_o  (ring_bad[r])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[r] <= '0;
                len_q[r]  <= '0;
            end else if (load) begin
                base_q[r] <= base_in[r];
                len_q[r]  <= len_in[r];
            end
        end

        drp_ring_index #(
            .IDX_W (IDX_W),
            .LEN_W (LEN_W)
        ) u_idx (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .adv_i   (adv_en && adv_in[r]),
            .len_i   (len_q[r]),
            .idx_o   (idx[r])
        );

        assign addr[r] = base_q[r] + (ADDR_W'(idx[r]) << DESC_SHIFT);
    end

    assign tx_desc_addr_o = addr[0];
    assign rx_desc_addr_o = addr[1];

    // R7: in the error state nothing but init moves the outputs
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && !init_i) |=> (cfg_err_o && $stable(tx_desc_addr_o) && $stable(rx_desc_addr_o)));

    // R8: restart from run or suspend lands both pointers on their bases
    p_restart_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !init_i && (state == ST_RUN || state == ST_SUSP))
        |=> (tx_desc_addr_o == base_q[0] && rx_desc_addr_o == base_q[1] && state == ST_RUN));

    // R9: a suspended ring does not move until it leaves suspend
    p_susp_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !init_i && !restart_i)
        |=> ($stable(tx_desc_addr_o) && $stable(rx_desc_addr_o)));

    // R2: outside the error state every address sits on a descriptor boundary
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_err_o |-> (tx_desc_addr_o[DESC_SHIFT-1:0] == '0 && rx_desc_addr_o[DESC_SHIFT-1:0] == '0));

    // R5 R6: a bad configuration always ends in the error state
    p_bad_cfg_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && cfg_bad) |=> cfg_err_o);
endmodule

// File: tb/desc_ring_ptr_mgr_tb.sv
`timescale 1ns/1ps
module desc_ring_ptr_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 0, restart_i = 0, suspend_i = 0, resume_i = 0;
    logic [31:0] tx_base_i = 0, rx_base_i = 0;
    logic [7:0]  tx_len_i = 0, rx_len_i = 0;
    logic        tx_adv_i = 0, rx_adv_i = 0;
    logic [31:0] tx_desc_addr_o, rx_desc_addr_o;
    logic        cfg_err_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [31:0] m_tb, m_rb;
    int          m_tl, m_rl, m_tn, m_rn;

    always #2 clk = ~clk;

    desc_ring_ptr_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .restart_i(restart_i),
        .suspend_i(suspend_i), .resume_i(resume_i),
        .tx_base_i(tx_base_i), .tx_len_i(tx_len_i),
        .rx_base_i(rx_base_i), .rx_len_i(rx_len_i),
        .tx_adv_i(tx_adv_i), .rx_adv_i(rx_adv_i),
        .tx_desc_addr_o(tx_desc_addr_o), .rx_desc_addr_o(rx_desc_addr_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_ptrs(input string tag);
        chk({tag, " tx"}, tx_desc_addr_o, m_tb + 32'((m_tn % m_tl) * 8));
        chk({tag, " rx"}, rx_desc_addr_o, m_rb + 32'((m_rn % m_rl) * 8));
    endtask

    // drive one cycle of controls after a falling edge; return at the next falling edge
    task automatic cyc(input logic ta, input logic ra, input logic ini,
                       input logic rs, input logic sp, input logic rm);
        tx_adv_i = ta; rx_adv_i = ra; init_i = ini;
        restart_i = rs; suspend_i = sp; resume_i = rm;
        @(negedge clk);
        tx_adv_i = 0; rx_adv_i = 0; init_i = 0;
        restart_i = 0; suspend_i = 0; resume_i = 0;
    endtask

    task automatic do_init(input logic [31:0] tb, input int tl, input logic [31:0] rb, input int rl);
        tx_base_i = tb; tx_len_i = 8'(tl); rx_base_i = rb; rx_len_i = 8'(rl);
        cyc(0, 0, 1, 0, 0, 0);
        m_tb = tb; m_tl = tl; m_rb = rb; m_rl = rl; m_tn = 0; m_rn = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int tl_set[6] = '{1, 2, 3, 4, 7, 8};
        int rl_set[6] = '{5, 1, 8, 2, 3, 6};
        logic [31:0] hold_t, hold_r;

        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 reset tx", tx_desc_addr_o, 0);
        chk("R11 reset rx", rx_desc_addr_o, 0);
        chk("R11 reset err", {31'b0, cfg_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R11 adv before init tx", tx_desc_addr_o, 0);
        chk("R11 adv before init rx", rx_desc_addr_o, 0);

        // R1 R2 R3 R4: sweep ring lengths, single and joint advances
        foreach (tl_set[i]) begin
            do_init(32'h0000_1000 + 32'(i) * 32'h100, tl_set[i],
                    32'h8000_0040 + 32'(i) * 32'h200, rl_set[i]);
            chk_ptrs("R1 init");
            chk("R1 err low", {31'b0, cfg_err_o}, 0);
            for (int k = 0; k < 2 * tl_set[i] + 1; k++) begin
                cyc(1, 0, 0, 0, 0, 0); m_tn++;
                chk_ptrs("R3 R4 tx only");
            end
            for (int k = 0; k < 2 * rl_set[i] + 1; k++) begin
                cyc(0, 1, 0, 0, 0, 0); m_rn++;
                chk_ptrs("R3 R4 rx only");
            end
            for (int k = 0; k < 9; k++) begin
                cyc(1, 1, 0, 0, 0, 0); m_tn++; m_rn++;
                chk_ptrs("R2 R3 both");
            end
        end

        // R4: full-size ring wraps after entry 127
        do_init(32'hFFFF_FC00, 128, 32'h0000_0008, 128);
        chk("R6 len 128 legal", {31'b0, cfg_err_o}, 0);
        for (int k = 0; k < 129; k++) begin
            cyc(1, (k % 2) == 0, 0, 0, 0, 0); m_tn++; if ((k % 2) == 0) m_rn++;
            chk_ptrs("R4 len128");
        end

        // R8: restart from run
        do_init(32'h0000_2000, 6, 32'h0000_3000, 4);
        repeat (3) begin cyc(1, 1, 0, 0, 0, 0); m_tn++; m_rn++; end
        cyc(0, 0, 0, 1, 0, 0); m_tn = 0; m_rn = 0;
        chk_ptrs("R8 restart run");

        // R9: suspend freezes, resume keeps positions
        repeat (2) begin cyc(1, 0, 0, 0, 0, 0); m_tn++; end
        cyc(0, 1, 0, 0, 1, 0); m_rn++;   // R10: advance with suspend is taken
        chk_ptrs("R10 adv with suspend");
        repeat (4) begin
            cyc(1, 1, 0, 0, 0, 0);
            chk_ptrs("R9 adv ignored in suspend");
        end
        cyc(0, 0, 0, 0, 0, 1);
        chk_ptrs("R9 resume keeps");
        cyc(1, 1, 0, 0, 0, 0); m_tn++; m_rn++;
        chk_ptrs("R9 runs after resume");

        // R8: restart from suspend returns to run at base
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0, 0); m_tn = 0; m_rn = 0;
        chk_ptrs("R8 restart susp");
        cyc(1, 0, 0, 0, 0, 0); m_tn++;
        chk_ptrs("R8 run after restart");

        // R10: restart with advance drops the advance
        cyc(1, 1, 0, 1, 0, 0); m_tn = 0; m_rn = 0;
        chk_ptrs("R10 restart drops adv");

        // R10: init beats restart and advance
        tx_base_i = 32'h0000_5000; tx_len_i = 3; rx_base_i = 32'h0000_6000; rx_len_i = 2;
        cyc(1, 1, 1, 1, 0, 0);
        m_tb = 32'h5000; m_tl = 3; m_rb = 32'h6000; m_rl = 2; m_tn = 0; m_rn = 0;
        chk_ptrs("R10 init priority");

        // R5 R7: misaligned base in either ring
        for (int k = 1; k < 8; k++) begin
            do_init(32'h0000_7000 + 32'(k), 4, 32'h0000_9000, 4);
            chk("R5 tx misaligned", {31'b0, cfg_err_o}, 1);
            do_init(32'h0000_7000, 4, 32'h0000_9000 + 32'(k), 4);
            chk("R5 rx misaligned", {31'b0, cfg_err_o}, 1);
            hold_t = tx_desc_addr_o; hold_r = rx_desc_addr_o;
            cyc(1, 1, 0, 0, 0, 0);
            cyc(0, 0, 0, 1, 0, 0);
            cyc(1, 1, 0, 0, 1, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk("R7 err tx hold", tx_desc_addr_o, hold_t);
            chk("R7 err rx hold", rx_desc_addr_o, hold_r);
            chk("R7 err sticky", {31'b0, cfg_err_o}, 1);
        end

        // R6: illegal lengths
        do_init(32'h0000_1000, 0, 32'h0000_2000, 4);
        chk("R6 tx len 0", {31'b0, cfg_err_o}, 1);
        do_init(32'h0000_1000, 4, 32'h0000_2000, 129);
        chk("R6 rx len 129", {31'b0, cfg_err_o}, 1);
        do_init(32'h0000_1000, 255, 32'h0000_2000, 4);
        chk("R6 tx len 255", {31'b0, cfg_err_o}, 1);

        // R7: a legal init clears the error
        do_init(32'h0000_1000, 5, 32'h0000_2000, 3);
        chk("R7 cleared", {31'b0, cfg_err_o}, 0);
        cyc(1, 1, 0, 0, 0, 0); m_tn++; m_rn++;
        chk_ptrs("R7 runs after clear");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule